// File: doc/BRIEF.md
# Dual-Path Control Register File

This block holds the 64-bit control state of a service-interface host bridge. Software reaches it over two routes that share one request port. The side-band route addresses registers by index, using the byte address shifted right by three. The memory-mapped route addresses a window whose byte offset is biased: its index is the offset shifted right by three, plus ten. Every access moves one whole 64-bit word, so the three low address bits are not used. Bit 63 is the most significant bit of the word, which matches the big-endian view of the registers.

Several registers have write aliases. The fault register and its mask each have an AND port and an OR port. The control register has a set port and a clear port. Two base registers keep only their legal bits. The base of the register window also has an enable bit in bit 0, and only the side-band route may write it. The block drives the decoded window base and its enable straight to the address map. It reports dropped writes, writes to unimplemented indices, and toggles of the control bit that enables the service-processor window, each as a one-cycle pulse.

Top module: `svc_bridge_regs`

## Requirements
- R1: The side-band index is req_addr >> 3. The memory-mapped index is (req_addr >> 3) + 0x0a. Address bits 2:0 are ignored on both routes, and every register is reachable from both routes wherever its index can be formed.
- R2: The fault register (index 0x00) is written whole by index 0x00, ANDed with the data by index 0x01 and ORed with the data by index 0x02. The mask register works the same way through indices 0x03, 0x04 and 0x05.
- R3: The control register (index 0x0e) is written whole by index 0x0e. Index 0x12 ORs the data into it, and index 0x13 clears every bit that is set in the data.
- R4: The window base register (index 0x0a) stores data & 0x0003_ffff_fff0_0000 together with data bit 0. The output win_base is the stored value with bit 0 cleared, and win_en is stored bit 0. Both follow a write on the clock edge that accepts it.
- R5: A memory-mapped write to index 0x0a leaves the window base unchanged and raises err_pulse.
- R6: The service-processor base register (index 0x0b) stores data & 0x0003_ffff_0000_0000.
- R7: The fault-action registers (0x06, 0x07), the status/error mask (0x0f) and the DMA upper address (0x14) store all 64 data bits.
- R8: The source compare register (index 0x1b) stores data & 0xffff_e00f_0000_0000, which keeps the compare field in bits 63:45 and the four enable and reset flags in bits 35:32.
- R9: A read of any index that has no readable register returns all ones. This covers the alias indices 0x01, 0x02, 0x04, 0x05, 0x12 and 0x13, and every index outside the map.
- R10: A write to the interrupt status register (index 0x15) changes nothing and raises err_pulse. A read of index 0x15 returns zero.
- R11: A write to an index that has no writable register changes no register and raises unimpl_pulse, without err_pulse.
- R12: ctl_chg_pulse rises when a write through any of the control indices 0x0e, 0x12 or 0x13 flips control bit 62. It stays low for every other write.
- R13: After reset, every register reads zero except the window base. The window base reads (WIN_BASE_DEFAULT & 0x0003_ffff_fff0_0000) | 1.
- R14: rsp_valid is high, and rsp_rdata holds the read value, in the cycle after a read is accepted. rsp_valid is low after a write. err_pulse, unimpl_pulse and ctl_chg_pulse each last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request accepted on this clock edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_from_mmio | input | 1 | 1 = memory-mapped route, 0 = side-band route |
| req_addr | input | ADDR_W | Byte address or byte offset |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| err_pulse | output | 1 | A forbidden write was dropped |
| unimpl_pulse | output | 1 | A write went to an unimplemented index |
| ctl_chg_pulse | output | 1 | Control bit 62 toggled |
| win_base | output | 64 | Decoded register window base |
| win_en | output | 1 | Register window enable |

## Verification
The case hardest to reach from the ports is the one where the two routes name the same register at different byte addresses, and the route's write permission decides the outcome. The stimulus therefore reaches most registers through one route and reads them back through the other. This shows the bias of ten in the index and proves that a memory-mapped write to the window base is dropped while a side-band write to it lands. The window base is first cleared and then re-enabled through the side-band route, so that the later rejected write has a known, non-default value to leave in place. The control-bit toggle pulse is driven by set, repeated set, a whole write that keeps bit 62, and clear, so both its edges and its quiet cases are covered.

// File: rtl/svc_regs_pkg.sv
package svc_regs_pkg;

    localparam int DW = 64;

    // Register indices.
    localparam logic [7:0] IX_FAULT     = 8'h00;
    localparam logic [7:0] IX_FAULT_AND = 8'h01;
    localparam logic [7:0] IX_FAULT_OR  = 8'h02;
    localparam logic [7:0] IX_MASK      = 8'h03;
    localparam logic [7:0] IX_MASK_AND  = 8'h04;
    localparam logic [7:0] IX_MASK_OR   = 8'h05;
    localparam logic [7:0] IX_ACT0      = 8'h06;
    localparam logic [7:0] IX_ACT1      = 8'h07;
    localparam logic [7:0] IX_WIN       = 8'h0a;
    localparam logic [7:0] IX_SPB       = 8'h0b;
    localparam logic [7:0] IX_CTL       = 8'h0e;
    localparam logic [7:0] IX_SEMR      = 8'h0f;
    localparam logic [7:0] IX_CTL_SET   = 8'h12;
    localparam logic [7:0] IX_CTL_CLR   = 8'h13;
    localparam logic [7:0] IX_DMA       = 8'h14;
    localparam logic [7:0] IX_STAT      = 8'h15;
    localparam logic [7:0] IX_SRC       = 8'h1b;

    // The memory-mapped window starts at this index.
    localparam logic [7:0] MMIO_BIAS = 8'h0a;

    localparam logic [DW-1:0] WIN_KEEP = 64'h0003_ffff_fff0_0000;
    localparam logic [DW-1:0] SPB_KEEP = 64'h0003_ffff_0000_0000;
    localparam logic [DW-1:0] SRC_KEEP = 64'hffff_e00f_0000_0000;
    localparam int            CTL_WIN2_BIT = 62;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_FAULT_WR, OP_FAULT_AND, OP_FAULT_OR,
        OP_MASK_WR,  OP_MASK_AND,  OP_MASK_OR,
        OP_ACT0, OP_ACT1, OP_WIN, OP_SPB,
        OP_CTL_WR, OP_CTL_SET, OP_CTL_CLR,
        OP_SEMR, OP_DMA, OP_SRC,
        OP_STAT_DENY, OP_WIN_DENY, OP_UNIMPL
    } wr_op_e;

    typedef enum logic [3:0] {
        RS_ONES, RS_FAULT, RS_MASK, RS_ACT0, RS_ACT1, RS_WIN,
        RS_SPB, RS_CTL, RS_SEMR, RS_DMA, RS_STAT, RS_SRC
    } rd_sel_e;

    typedef struct packed {
        logic    is_read;
        logic    is_write;
        wr_op_e  op;
        rd_sel_e rsel;
    } dec_t;

    // Registers with AND/OR (or set/clear) aliases.
    localparam int N_ALIAS  = 3;
    localparam int AL_FAULT = 0;
    localparam int AL_MASK  = 1;
    localparam int AL_CTL   = 2;

    // Registers written only as a whole value, through a keep mask.
    localparam int N_PLAIN  = 7;
    localparam int PL_ACT0  = 0;
    localparam int PL_ACT1  = 1;
    localparam int PL_WIN   = 2;
    localparam int PL_SPB   = 3;
    localparam int PL_SEMR  = 4;
    localparam int PL_DMA   = 5;
    localparam int PL_SRC   = 6;

    localparam wr_op_e PLAIN_OP [N_PLAIN] = '{
        OP_ACT0, OP_ACT1, OP_WIN, OP_SPB, OP_SEMR, OP_DMA, OP_SRC
    };
    localparam logic [DW-1:0] PLAIN_KEEP [N_PLAIN] = '{
        '1, '1, WIN_KEEP | 64'h1, SPB_KEEP, '1, '1, SRC_KEEP
    };

    function automatic wr_op_e wr_lookup(input logic [7:0] ix, input logic mm);
        case (ix)
            IX_FAULT:     return OP_FAULT_WR;
            IX_FAULT_AND: return OP_FAULT_AND;
            IX_FAULT_OR:  return OP_FAULT_OR;
            IX_MASK:      return OP_MASK_WR;
            IX_MASK_AND:  return OP_MASK_AND;
            IX_MASK_OR:   return OP_MASK_OR;
            IX_ACT0:      return OP_ACT0;
            IX_ACT1:      return OP_ACT1;
            IX_WIN:       return mm ? OP_WIN_DENY : OP_WIN;
            IX_SPB:       return OP_SPB;
            IX_CTL:       return OP_CTL_WR;
            IX_SEMR:      return OP_SEMR;
            IX_CTL_SET:   return OP_CTL_SET;
            IX_CTL_CLR:   return OP_CTL_CLR;
            IX_DMA:       return OP_DMA;
            IX_STAT:      return OP_STAT_DENY;
            IX_SRC:       return OP_SRC;
            default:      return OP_UNIMPL;
        endcase
    endfunction

    function automatic rd_sel_e rd_lookup(input logic [7:0] ix);
        case (ix)
            IX_FAULT: return RS_FAULT;
            IX_MASK:  return RS_MASK;
            IX_ACT0:  return RS_ACT0;
            IX_ACT1:  return RS_ACT1;
            IX_WIN:   return RS_WIN;
            IX_SPB:   return RS_SPB;
            IX_CTL:   return RS_CTL;
            IX_SEMR:  return RS_SEMR;
            IX_DMA:   return RS_DMA;
            IX_STAT:  return RS_STAT;
            IX_SRC:   return RS_SRC;
            default:  return RS_ONES;
        endcase
    endfunction

endpackage

// File: rtl/svc_index_decode.sv
module svc_index_decode
    import svc_regs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_from_mmio,
    input  logic [ADDR_W-1:0] req_addr,
    output dec_t              dec
);
    // Wide enough for the word address plus the window bias, and at least 9 bits.
    localparam int IDX_W = (ADDR_W - 2 > 9) ? ADDR_W - 2 : 9;

    logic [IDX_W-1:0] ix_full;
    logic             in_map;
    logic [7:0]       ix;

    always_comb begin
        ix_full = IDX_W'(req_addr[ADDR_W-1:3])
                + (req_from_mmio ? IDX_W'(MMIO_BIAS) : IDX_W'(0));
        in_map  = (ix_full <= IDX_W'(255));
        ix      = ix_full[7:0];

        dec.is_read  = req_valid && !req_write;
        dec.is_write = req_valid && req_write;
        dec.op       = OP_NONE;
        dec.rsel     = RS_ONES;
        if (dec.is_write) begin
            dec.op = in_map ? wr_lookup(ix, req_from_mmio) : OP_UNIMPL;
        end
        if (in_map) begin
            dec.rsel = rd_lookup(ix);
        end
    end
endmodule

// File: rtl/svc_alias_reg.sv
module svc_alias_reg #(
    parameter int          W       = 64,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         and_en,
    input  logic         or_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = q;
        if (ld) begin
            nxt = d;
        end else if (and_en) begin
            nxt = q & d;
        end else if (or_en) begin
            nxt = q | d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/svc_plain_regs.sv
module svc_plain_regs
    import svc_regs_pkg::*;
#(
    parameter logic [DW-1:0] WIN_BASE_DEFAULT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_op_e        op,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q [N_PLAIN]
);
    for (genvar g = 0; g < N_PLAIN; g++) begin : g_slot
        localparam logic [DW-1:0] RV =
            (g == PL_WIN) ? ((WIN_BASE_DEFAULT & PLAIN_KEEP[g]) | 64'h1) : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= RV;
            end else if (op == PLAIN_OP[g]) begin
                q[g] <= wdata & PLAIN_KEEP[g];
            end
        end
    end
endmodule

// File: rtl/svc_bridge_regs.sv
module svc_bridge_regs
    import svc_regs_pkg::*;
#(
    parameter int            ADDR_W           = 16,
    parameter logic [63:0]   WIN_BASE_DEFAULT = 64'h0000_0003_fff0_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_from_mmio,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              err_pulse,
    output logic              unimpl_pulse,
    output logic              ctl_chg_pulse,
    output logic [63:0]       win_base,
    output logic              win_en
);
    dec_t dec;

    svc_index_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_from_mmio (req_from_mmio),
        .req_addr      (req_addr),
        .dec           (dec)
    );

    // Alias-capable registers: fault, mask, control.
    logic [N_ALIAS-1:0] al_ld, al_and, al_or;
    logic [63:0]        al_d   [N_ALIAS];
    logic [63:0]        al_q   [N_ALIAS];
    logic [63:0]        al_nxt [N_ALIAS];

    always_comb begin
        al_ld  = '0;
        al_and = '0;
        al_or  = '0;
        for (int i = 0; i < N_ALIAS; i++) begin
            al_d[i] = req_wdata;
        end
        // Clearing is an AND with the inverted data.
        al_d[AL_CTL] = (dec.op == OP_CTL_CLR) ? ~req_wdata : req_wdata;
        al_ld[AL_FAULT]  = (dec.op == OP_FAULT_WR);
        al_and[AL_FAULT] = (dec.op == OP_FAULT_AND);
        al_or[AL_FAULT]  = (dec.op == OP_FAULT_OR);
        al_ld[AL_MASK]   = (dec.op == OP_MASK_WR);
        al_and[AL_MASK]  = (dec.op == OP_MASK_AND);
        al_or[AL_MASK]   = (dec.op == OP_MASK_OR);
        al_ld[AL_CTL]    = (dec.op == OP_CTL_WR);
        al_and[AL_CTL]   = (dec.op == OP_CTL_CLR);
        al_or[AL_CTL]    = (dec.op == OP_CTL_SET);
    end

    for (genvar a = 0; a < N_ALIAS; a++) begin : g_alias
        svc_alias_reg #(.W(64), .RST_VAL('0)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .ld     (al_ld[a]),
            .and_en (al_and[a]),
            .or_en  (al_or[a]),
            .d      (al_d[a]),
            .q      (al_q[a]),
            .nxt    (al_nxt[a])
        );
    end

    logic [63:0] pl_q [N_PLAIN];

    svc_plain_regs #(.WIN_BASE_DEFAULT(WIN_BASE_DEFAULT)) u_plain (
        .clk   (clk),
        .rst   (rst),
        .op    (dec.op),
        .wdata (req_wdata),
        .q     (pl_q)
    );

    // Names seen by the bound checker.
    logic [63:0] fault_q, ctl_q;
    assign fault_q = al_q[AL_FAULT];
    assign ctl_q   = al_q[AL_CTL];

    // Interrupt status has no setter in this block; it reads as zero.
    logic [63:0] stat_q;
    assign stat_q = '0;

    logic [63:0] rd_val;
    always_comb begin
        case (dec.rsel)
            RS_FAULT: rd_val = al_q[AL_FAULT];
            RS_MASK:  rd_val = al_q[AL_MASK];
            RS_CTL:   rd_val = al_q[AL_CTL];
            RS_ACT0:  rd_val = pl_q[PL_ACT0];
            RS_ACT1:  rd_val = pl_q[PL_ACT1];
            RS_WIN:   rd_val = pl_q[PL_WIN];
            RS_SPB:   rd_val = pl_q[PL_SPB];
            RS_SEMR:  rd_val = pl_q[PL_SEMR];
            RS_DMA:   rd_val = pl_q[PL_DMA];
            RS_STAT:  rd_val = stat_q;
            RS_SRC:   rd_val = pl_q[PL_SRC];
            default:  rd_val = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            err_pulse     <= 1'b0;
            unimpl_pulse  <= 1'b0;
            ctl_chg_pulse <= 1'b0;
        end else begin
            rsp_valid     <= dec.is_read;
            if (dec.is_read) begin
                rsp_rdata <= rd_val;
            end
            err_pulse     <= (dec.op == OP_WIN_DENY) || (dec.op == OP_STAT_DENY);
            unimpl_pulse  <= (dec.op == OP_UNIMPL);
            ctl_chg_pulse <= al_nxt[AL_CTL][CTL_WIN2_BIT] ^ al_q[AL_CTL][CTL_WIN2_BIT];
        end
    end

    assign win_base = pl_q[PL_WIN] & WIN_KEEP;
    assign win_en   = pl_q[PL_WIN][0];
endmodule

// File: rtl/svc_bridge_regs_chk.sv
module svc_bridge_regs_chk
    import svc_regs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_from_mmio,
    input logic [ADDR_W-1:0] req_addr,
    input logic [63:0]       req_wdata,
    input logic              rsp_valid,
    input logic [63:0]       rsp_rdata,
    input logic              err_pulse,
    input logic              unimpl_pulse,
    input logic              ctl_chg_pulse,
    input logic [63:0]       win_base,
    input logic              win_en,
    input logic [63:0]       fault_q,
    input logic [63:0]       ctl_q
);
    localparam int WA = ADDR_W - 3;

    logic [WA-1:0] wa;
    logic sb_fault_and, sb_ctl_clr, sb_rd_alias, mm_win_wr, stat_wr;

    always_comb begin
        wa           = req_addr[ADDR_W-1:3];
        sb_fault_and = req_valid && req_write && !req_from_mmio && wa == WA'(1);
        sb_ctl_clr   = req_valid && req_write && !req_from_mmio && wa == WA'(8'h13);
        sb_rd_alias  = req_valid && !req_write && !req_from_mmio && wa == WA'(1);
        mm_win_wr    = req_valid && req_write && req_from_mmio && wa == WA'(0);
        stat_wr      = req_valid && req_write &&
                       ((!req_from_mmio && wa == WA'(8'h15)) ||
                        (req_from_mmio && wa == WA'(8'h0b)));
    end

    p_fault_and_r2: assert property (@(posedge clk) disable iff (rst)
        sb_fault_and |=> fault_q == ($past(fault_q) & $past(req_wdata)));

    p_ctl_clear_r3: assert property (@(posedge clk) disable iff (rst)
        sb_ctl_clr |=> (ctl_q & $past(req_wdata)) == '0);

    p_win_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (win_base & ~WIN_KEEP) == '0);

    p_mmio_win_locked_r5: assert property (@(posedge clk) disable iff (rst)
        mm_win_wr |=> err_pulse && $stable(win_base) && $stable(win_en));

    p_alias_read_ones_r9: assert property (@(posedge clk) disable iff (rst)
        sb_rd_alias |=> rsp_valid && rsp_rdata == '1);

    p_stat_write_err_r10: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> err_pulse && !unimpl_pulse);

    p_unimpl_not_err_r11: assert property (@(posedge clk) disable iff (rst)
        unimpl_pulse |-> !err_pulse && $past(req_valid && req_write));

    p_chg_from_write_r12: assert property (@(posedge clk) disable iff (rst)
        ctl_chg_pulse |-> $past(req_valid && req_write) && $changed(ctl_q[62]));

    p_rsp_after_read_r14: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind svc_bridge_regs svc_bridge_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_from_mmio (req_from_mmio),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .err_pulse     (err_pulse),
    .unimpl_pulse  (unimpl_pulse),
    .ctl_chg_pulse (ctl_chg_pulse),
    .win_base      (win_base),
    .win_en        (win_en),
    .fault_q       (fault_q),
    .ctl_q         (ctl_q)
);

// File: tb/svc_bridge_regs_bench.sv
module svc_bridge_regs_bench;

    localparam logic [63:0] DEF_BASE = 64'hfff0_1234_5678_9abe;
    localparam logic [63:0] DEF_READ = 64'h0000_1234_5670_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_from_mmio = 1'b0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, err_pulse, unimpl_pulse, ctl_chg_pulse, win_en;
    logic [63:0] rsp_rdata, win_base;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    svc_bridge_regs #(.ADDR_W(16), .WIN_BASE_DEFAULT(DEF_BASE)) u_svc_bridge_regs (
        .clk, .rst, .req_valid, .req_write, .req_from_mmio, .req_addr, .req_wdata,
        .rsp_valid, .rsp_rdata, .err_pulse, .unimpl_pulse, .ctl_chg_pulse,
        .win_base, .win_en
    );

    typedef struct packed {
        logic        wr;
        logic        mm;
        logic [15:0] addr;
        logic [63:0] data;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 16'h0000, 64'hf0f0_f0f0_0000_ffff, 64'h0, 8'd2},                // R2 fault
        '{1'b1, 1'b0, 16'h0008, 64'hff00_ff00_ffff_00ff, 64'h0, 8'd2},                // R2 AND
        '{1'b1, 1'b0, 16'h0010, 64'h0000_0000_1234_0000, 64'h0, 8'd2},                // R2 OR
        '{1'b0, 1'b0, 16'h0000, 64'h0, 64'hf000_f000_1234_00ff, 8'd2},
        '{1'b1, 1'b0, 16'h0018, 64'h00ff_00ff_00ff_00ff, 64'h0, 8'd2},                // R2 mask
        '{1'b1, 1'b0, 16'h0020, 64'h0f0f_0f0f_0f0f_0f0f, 64'h0, 8'd2},
        '{1'b1, 1'b0, 16'h0028, 64'h8000_0000_0000_0000, 64'h0, 8'd2},
        '{1'b0, 1'b0, 16'h0018, 64'h0, 64'h800f_000f_000f_000f, 8'd2},
        '{1'b1, 1'b1, 16'h0020, 64'h0000_0000_0000_00f0, 64'h0, 8'd3},                // R3 direct
        '{1'b1, 1'b1, 16'h0040, 64'h8000_0000_0000_0001, 64'h0, 8'd3},                // R3 set
        '{1'b1, 1'b0, 16'h0098, 64'h0000_0000_0000_0030, 64'h0, 8'd3},                // R3 clear
        '{1'b0, 1'b1, 16'h0020, 64'h0, 64'h8000_0000_0000_00c1, 8'd3},
        '{1'b1, 1'b0, 16'h0058, 64'hffff_ffff_ffff_ffff, 64'h0, 8'd6},                // R6
        '{1'b0, 1'b1, 16'h0008, 64'h0, 64'h0003_ffff_0000_0000, 8'd6},
        '{1'b1, 1'b1, 16'h0088, 64'hffff_ffff_ffff_ffff, 64'h0, 8'd8},                // R8
        '{1'b0, 1'b0, 16'h00d8, 64'h0, 64'hffff_e00f_0000_0000, 8'd8},
        '{1'b1, 1'b0, 16'h0030, 64'h0123_4567_89ab_cdef, 64'h0, 8'd7},                // R7
        '{1'b0, 1'b0, 16'h0035, 64'h0, 64'h0123_4567_89ab_cdef, 8'd1},                // R1 low bits
        '{1'b1, 1'b0, 16'h0038, 64'h1111_2222_3333_4444, 64'h0, 8'd7},
        '{1'b0, 1'b0, 16'h0038, 64'h0, 64'h1111_2222_3333_4444, 8'd7},
        '{1'b1, 1'b1, 16'h0050, 64'hdead_beef_0bad_f00d, 64'h0, 8'd1},                // R1 mmio
        '{1'b0, 1'b0, 16'h00a0, 64'h0, 64'hdead_beef_0bad_f00d, 8'd1},
        '{1'b1, 1'b1, 16'h002c, 64'h5555_aaaa_5555_aaaa, 64'h0, 8'd7},
        '{1'b0, 1'b0, 16'h0078, 64'h0, 64'h5555_aaaa_5555_aaaa, 8'd7},
        '{1'b0, 1'b0, 16'h0008, 64'h0, 64'hffff_ffff_ffff_ffff, 8'd9},                // R9
        '{1'b0, 1'b1, 16'h0048, 64'h0, 64'hffff_ffff_ffff_ffff, 8'd9},
        '{1'b0, 1'b1, 16'h00f8, 64'h0, 64'hffff_ffff_ffff_ffff, 8'd9}
    };

    logic        g_valid, g_err, g_unimpl, g_chg;
    logic [63:0] g_rdata;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic mm, input logic [15:0] a,
                          input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_from_mmio = mm;
        req_addr = a;
        req_wdata = d;
        @(negedge clk);
        g_valid  = rsp_valid;
        g_rdata  = rsp_rdata;
        g_err    = err_pulse;
        g_unimpl = unimpl_pulse;
        g_chg    = ctl_chg_pulse;
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R13: reset state
        check("R13 win_en", {63'd0, win_en}, 64'd1);
        check("R13 win_base", win_base, 64'h0000_1234_5670_0000);
        access(1'b0, 1'b0, 16'h0050, '0);
        check("R13 win reg", g_rdata, DEF_READ);
        check("R14 rsp_valid on read", {63'd0, g_valid}, 64'd1);
        access(1'b0, 1'b0, 16'h0000, '0);
        check("R13 fault zero", g_rdata, 64'h0);
        access(1'b0, 1'b1, 16'h0058, '0);
        check("R10 stat reads zero", g_rdata, 64'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].mm, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr) begin
                check($sformatf("R%0d vec %0d", VECS[i].req, i), g_rdata, VECS[i].exp);
            end
        end

        // R4: side-band writes to the window base are masked
        access(1'b1, 1'b0, 16'h0050, 64'hffff_ffff_ffff_fffe);
        check("R14 rsp_valid low on write", {63'd0, g_valid}, 64'd0);
        check("R4 win_en cleared", {63'd0, win_en}, 64'd0);
        check("R4 win_base masked", win_base, 64'h0003_ffff_fff0_0000);
        access(1'b0, 1'b1, 16'h0000, '0);
        check("R4 win reg via mmio", g_rdata, 64'h0003_ffff_fff0_0000);
        access(1'b1, 1'b0, 16'h0050, 64'h0000_0000_0010_0001);
        check("R4 win_en set", {63'd0, win_en}, 64'd1);
        check("R4 win_base", win_base, 64'h0000_0000_0010_0000);

        // R5: memory-mapped write to the window base is dropped
        access(1'b1, 1'b1, 16'h0000, 64'h0);
        check("R5 err_pulse", {63'd0, g_err}, 64'd1);
        check("R5 win_base kept", win_base, 64'h0000_0000_0010_0000);
        check("R5 win_en kept", {63'd0, win_en}, 64'd1);
        @(negedge clk);
        check("R14 err one cycle", {63'd0, err_pulse}, 64'd0);

        // R10: interrupt status write ignored
        access(1'b1, 1'b0, 16'h00a8, 64'hffff_ffff_ffff_ffff);
        check("R10 err_pulse", {63'd0, g_err}, 64'd1);
        check("R10 no unimpl", {63'd0, g_unimpl}, 64'd0);
        access(1'b0, 1'b0, 16'h00a8, '0);
        check("R10 stat still zero", g_rdata, 64'h0);

        // R11: unimplemented writes
        access(1'b1, 1'b0, 16'h0040, 64'h0);
        check("R11 unimpl_pulse", {63'd0, g_unimpl}, 64'd1);
        check("R11 no err", {63'd0, g_err}, 64'd0);
        access(1'b1, 1'b0, 16'h0100, 64'h0);
        check("R11 unimpl out of map", {63'd0, g_unimpl}, 64'd1);
        access(1'b0, 1'b0, 16'h0000, '0);
        check("R11 fault untouched", g_rdata, 64'hf000_f000_1234_00ff);
        @(negedge clk);
        check("R14 unimpl one cycle", {63'd0, unimpl_pulse}, 64'd0);

        // R12: control bit 62 toggle strobe
        access(1'b1, 1'b0, 16'h0090, 64'h4000_0000_0000_0000);
        check("R12 set flips", {63'd0, g_chg}, 64'd1);
        access(1'b0, 1'b0, 16'h0070, '0);
        check("R3 ctl after set", g_rdata, 64'hc000_0000_0000_00c1);
        access(1'b1, 1'b1, 16'h0040, 64'h4000_0000_0000_0000);
        check("R12 repeated set quiet", {63'd0, g_chg}, 64'd0);
        access(1'b1, 1'b0, 16'h0070, 64'h4000_0000_0000_0000);
        check("R12 direct keep quiet", {63'd0, g_chg}, 64'd0);
        access(1'b1, 1'b1, 16'h0048, 64'h4000_0000_0000_0000);
        check("R12 clear flips", {63'd0, g_chg}, 64'd1);
        access(1'b0, 1'b1, 16'h0020, '0);
        check("R3 ctl after clear", g_rdata, 64'h0);

        // R13: reset again restores defaults
        do_reset();
        access(1'b0, 1'b0, 16'h0000, '0);
        check("R13 fault after reset", g_rdata, 64'h0);
        access(1'b0, 1'b1, 16'h0000, '0);
        check("R13 win after reset", g_rdata, DEF_READ);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R14 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule